// File: doc/BRIEF.md
# Pipelined SRAM Target with Wait States and Fault Replies

This block is a single on-chip RAM target on an AHB-Lite style bus with a 32-bit address and 32-bit data path. When the bus offers a real transfer, the block latches address and control at the clock edge. The data phase then occupies the following cycle or cycles. Write data arriving in the data phase is stored through byte-lane enables. Read data is presented in the cycle that completes the data phase.

A fixed number of stall cycles (parameter `WAIT_STATES`, 0 to 3) holds HREADYOUT low ahead of every successful completion. Addresses outside the mapped window, misaligned accesses and sizes wider than the data path are refused with the two-cycle ERROR reply. Each beat carries its own address, so the burst type is not an input.

A controller with five named states does the sequencing:
- `S_READY`: open, nothing pending.
- `S_STALL`: counting stall cycles.
- `S_DONE`: completing data phase.
- `S_FAULT1`: first ERROR cycle, ready low.
- `S_FAULT2`: second ERROR cycle, ready high.

From any open state (`S_READY`, `S_DONE`, `S_FAULT2`) the next state is chosen as follows:
- An accepted bad transfer leads to `S_FAULT1`.
- An accepted good transfer leads to `S_STALL`, or to `S_DONE` when `WAIT_STATES` is 0.
- No accepted transfer leads to `S_READY`.

The remaining transitions are fixed:
- `S_STALL` goes to `S_DONE` once its counter reaches zero.
- `S_FAULT1` always goes to `S_FAULT2`.

Top module: `ahbl_sram_sub`

## Requirements
- R1: While reset is asserted and in the first cycle after it, HREADYOUT is 1 and HRESP is 0 (OKAY).
- R2: A transfer is taken only when HSEL=1, HTRANS is 2'b10 (NONSEQ) or 2'b11 (SEQ), and HREADY=1. Transfers with HTRANS 2'b00 (IDLE) or 2'b01 (BUSY), and any cycle with HSEL=0, leave memory unchanged. The next cycle then shows HREADYOUT=1 and HRESP=0.
- R3: Write data is taken from HWDATA in the cycle that completes the data phase (HREADYOUT=1) following the address phase, and is stored at the address latched in that address phase.
- R4: Every successful transfer holds HREADYOUT low with HRESP=0 for exactly `WAIT_STATES` cycles after its address phase, then completes with HREADYOUT=1.
- R5: In the completing cycle of a read, HRDATA carries the whole 32-bit word containing the latched address, with byte k on bits 8k+7:8k.
- R6: A taken transfer with HADDR at or above MEM_WORDS*4 (0x400 by default) gets ERROR. The first cycle shows HRESP=1 with HREADYOUT=0. The second cycle shows HRESP=1 with HREADYOUT=1. No stall cycles precede the ERROR.
- R7: A halfword (HSIZE=1) with HADDR[0]=1, a word (HSIZE=2) with HADDR[1:0]≠0, or any HSIZE above 2 gets the same two-cycle ERROR as R6.
- R8: HSIZE=0 writes only byte lane HADDR[1:0]. HSIZE=1 writes lanes 2·HADDR[1] and 2·HADDR[1]+1. HSIZE=2 writes all four lanes.
- R9: A write answered with ERROR leaves every memory location unchanged.
- R10: A new address phase is accepted in the completing cycle of the previous transfer. A read issued right after a write to the same word returns the newly written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Bus clock, rising edge active |
| hresetn | input | 1 | Asynchronous reset, active low |
| hsel | input | 1 | Target select |
| haddr | input | 32 | Byte address of the address phase |
| htrans | input | 2 | Transfer type: 00 idle, 01 busy, 10 nonseq, 11 seq |
| hwrite | input | 1 | 1 for write, 0 for read |
| hsize | input | 3 | Log2 of bytes per beat |
| hwdata | input | 32 | Write data of the current data phase |
| hready | input | 1 | Bus-level ready; a transfer is taken only when high |
| hrdata | output | 32 | Read data, valid in the completing cycle of a read |
| hreadyout | output | 1 | Low to stretch the data phase |
| hresp | output | 1 | 0 OKAY, 1 ERROR |

## Verification
Take the cycle after the clock edge that latches an address phase as data-phase cycle 1. For a good transfer, HREADYOUT is low in data-phase cycles 1 to `WAIT_STATES` and high in cycle `WAIT_STATES`+1. That last cycle is where HRDATA is due and where HWDATA is stored at its closing edge. A refused transfer shows ERROR with ready low in data-phase cycle 1 and ERROR with ready high in cycle 2. The bench keeps a behavioural model that steps at every rising edge. It compares ready, response and read data 1 ns after each edge, once the registered outputs have settled. It drives all inputs on falling edges.

// File: rtl/ahbl_sub_pkg.sv
package ahbl_sub_pkg;

    localparam logic [1:0] TR_IDLE   = 2'b00;
    localparam logic [1:0] TR_BUSY   = 2'b01;
    localparam logic [1:0] TR_NONSEQ = 2'b10;
    localparam logic [1:0] TR_SEQ    = 2'b11;

    localparam logic RESP_OKAY  = 1'b0;
    localparam logic RESP_ERROR = 1'b1;

    typedef enum logic [2:0] {
        S_READY  = 3'd0,
        S_STALL  = 3'd1,
        S_DONE   = 3'd2,
        S_FAULT1 = 3'd3,
        S_FAULT2 = 3'd4
    } phase_e;

endpackage

// File: rtl/ahbl_sub_decode.sv
module ahbl_sub_decode
    import ahbl_sub_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int MEM_WORDS = 256
) (
    input  logic                          hsel,
    input  logic [1:0]                    htrans,
    input  logic                          hready,
    input  logic [ADDR_W-1:0]             haddr,
    input  logic [2:0]                    hsize,
    output logic                          take,
    output logic                          bad,
    output logic [DATA_W/8-1:0]           lanes,
    output logic [$clog2(MEM_WORDS)-1:0]  word_idx
);
    localparam int LANES = DATA_W / 8;
    localparam int OFF_W = $clog2(LANES);
    localparam int IDX_W = $clog2(MEM_WORDS);
    localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(MEM_WORDS * LANES);

    logic [OFF_W-1:0] off;
    logic             unmapped;
    logic             oversize;
    logic             misaligned;

    assign off      = haddr[OFF_W-1:0];
    assign word_idx = haddr[OFF_W +: IDX_W];
    assign take     = hsel && hready && (htrans == TR_NONSEQ || htrans == TR_SEQ);

    always_comb begin
        unmapped   = (haddr >= LIMIT);
        oversize   = (int'(hsize) > OFF_W);
        misaligned = ((int'(off) & ((1 << hsize) - 1)) != 0);
        bad        = unmapped || oversize || misaligned;
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        always_comb begin
            lanes[i] = ((i >> hsize) == (int'(off) >> hsize));
        end
    end

endmodule

// File: rtl/ahbl_sub_ctrl.sv
module ahbl_sub_ctrl
    import ahbl_sub_pkg::*;
#(
    parameter int WAIT_STATES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic take,
    input  logic bad,
    output logic hreadyout,
    output logic hresp,
    output logic done
);
    localparam int CNT_W = (WAIT_STATES > 1) ? $clog2(WAIT_STATES) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD =
        (WAIT_STATES > 0) ? CNT_W'(WAIT_STATES - 1) : '0;

    phase_e           st;
    phase_e           st_nxt;
    logic [CNT_W-1:0] cnt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_READY;
        else        st <= st_nxt;
    end

    // next state
    always_comb begin
        st_nxt = st;
        unique case (st)
            S_READY, S_DONE, S_FAULT2: begin
                if (take) begin
                    if (bad)                   st_nxt = S_FAULT1;
                    else if (WAIT_STATES == 0) st_nxt = S_DONE;
                    else                       st_nxt = S_STALL;
                end else begin
                    st_nxt = S_READY;
                end
            end
            S_STALL:  if (cnt == '0) st_nxt = S_DONE;
            S_FAULT1: st_nxt = S_FAULT2;
            default:  st_nxt = S_READY;
        endcase
    end

    // stall counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                   cnt <= '0;
        else if (st_nxt == S_STALL && st != S_STALL)  cnt <= CNT_LOAD;
        else if (st == S_STALL && cnt != '0)          cnt <= cnt - 1'b1;
    end

    // outputs
    always_comb begin
        hreadyout = 1'b1;
        hresp     = RESP_OKAY;
        done      = 1'b0;
        unique case (st)
            S_READY:  ;
            S_STALL:  hreadyout = 1'b0;
            S_DONE:   done = 1'b1;
            S_FAULT1: begin hreadyout = 1'b0; hresp = RESP_ERROR; end
            S_FAULT2: hresp = RESP_ERROR;
            default:  ;
        endcase
    end

endmodule

// File: rtl/ahbl_sub_ram.sv
module ahbl_sub_ram #(
    parameter int DATA_W    = 32,
    parameter int MEM_WORDS = 256
) (
    input  logic                          clk,
    input  logic                          we,
    input  logic [DATA_W/8-1:0]           lanes,
    input  logic [$clog2(MEM_WORDS)-1:0]  idx,
    input  logic [DATA_W-1:0]             wdata,
    output logic [DATA_W-1:0]             rdata
);
    localparam int LANES = DATA_W / 8;

    for (genvar i = 0; i < LANES; i++) begin : g_bank
        logic [7:0] bank [MEM_WORDS];

        always_ff @(posedge clk) begin
            if (we && lanes[i]) bank[idx] <= wdata[8*i +: 8];
        end

        assign rdata[8*i +: 8] = bank[idx];
    end

endmodule

// File: rtl/ahbl_sram_sub.sv
module ahbl_sram_sub
    import ahbl_sub_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32,
    parameter int MEM_WORDS   = 256,
    parameter int WAIT_STATES = 2
) (
    input  logic              hclk,
    input  logic              hresetn,
    input  logic              hsel,
    input  logic [ADDR_W-1:0] haddr,
    input  logic [1:0]        htrans,
    input  logic              hwrite,
    input  logic [2:0]        hsize,
    input  logic [DATA_W-1:0] hwdata,
    input  logic              hready,
    output logic [DATA_W-1:0] hrdata,
    output logic              hreadyout,
    output logic              hresp
);
    localparam int LANES = DATA_W / 8;
    localparam int IDX_W = $clog2(MEM_WORDS);

    logic             take;
    logic             bad;
    logic [LANES-1:0] lanes_d;
    logic [IDX_W-1:0] idx_d;
    logic             done;

    logic [LANES-1:0] lanes_q;
    logic [IDX_W-1:0] idx_q;
    logic             wr_q;
    logic             mem_we;
    logic [DATA_W-1:0] mem_rd;

    ahbl_sub_decode #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .MEM_WORDS (MEM_WORDS)
    ) u_dec (
        .hsel     (hsel),
        .htrans   (htrans),
        .hready   (hready),
        .haddr    (haddr),
        .hsize    (hsize),
        .take     (take),
        .bad      (bad),
        .lanes    (lanes_d),
        .word_idx (idx_d)
    );

    ahbl_sub_ctrl #(
        .WAIT_STATES (WAIT_STATES)
    ) u_ctrl (
        .clk       (hclk),
        .rst_n     (hresetn),
        .take      (take),
        .bad       (bad),
        .hreadyout (hreadyout),
        .hresp     (hresp),
        .done      (done)
    );

    // address-phase capture
    always_ff @(posedge hclk or negedge hresetn) begin
        if (!hresetn) begin
            lanes_q <= '0;
            idx_q   <= '0;
            wr_q    <= 1'b0;
        end else if (take) begin
            lanes_q <= lanes_d;
            idx_q   <= idx_d;
            wr_q    <= hwrite && !bad;
        end
    end

    assign mem_we = done && wr_q;

    ahbl_sub_ram #(
        .DATA_W    (DATA_W),
        .MEM_WORDS (MEM_WORDS)
    ) u_ram (
        .clk   (hclk),
        .we    (mem_we),
        .lanes (lanes_q),
        .idx   (idx_q),
        .wdata (hwdata),
        .rdata (mem_rd)
    );

    assign hrdata = (done && !wr_q) ? mem_rd : '0;

endmodule

// File: rtl/ahbl_sub_sva.sv
module ahbl_sub_sva #(
    parameter int WAIT_STATES = 2
) (
    input logic       clk,
    input logic       rst_n,
    input logic       hsel,
    input logic [1:0] htrans,
    input logic       hready,
    input logic [1:0] addr_lo,
    input logic [2:0] hsize,
    input logic       hreadyout,
    input logic       hresp,
    input logic       mem_we
);
    logic [3:0] wait_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      wait_run <= '0;
        else if (!hreadyout && !hresp)   wait_run <= (wait_run == 4'hF) ? wait_run : wait_run + 4'd1;
        else                             wait_run <= '0;
    end

    a_r1_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (hreadyout && !hresp));

    a_r2_noop_okay: assert property (@(posedge clk) disable iff (!rst_n)
        (hready && hreadyout && !(hsel && (htrans == 2'b10 || htrans == 2'b11)))
        |=> (hreadyout && !hresp));

    a_r4_stall_bound: assert property (@(posedge clk) disable iff (!rst_n)
        wait_run <= 4'(WAIT_STATES));

    a_r6_err_first: assert property (@(posedge clk) disable iff (!rst_n)
        (hresp && !hreadyout) |=> (hresp && hreadyout));

    a_r6_err_second: assert property (@(posedge clk) disable iff (!rst_n)
        (hresp && hreadyout) |-> $past(hresp && !hreadyout));

    a_r7_word_misalign: assert property (@(posedge clk) disable iff (!rst_n)
        (hsel && hready && hreadyout && htrans[1] && hsize == 3'd2 && addr_lo != 2'b00)
        |=> (hresp && !hreadyout));

    a_r9_no_store_on_err: assert property (@(posedge clk) disable iff (!rst_n)
        (hresp && !hreadyout) |=> !mem_we);

endmodule

bind ahbl_sram_sub ahbl_sub_sva #(.WAIT_STATES(WAIT_STATES)) u_sva (
    .clk       (hclk),
    .rst_n     (hresetn),
    .hsel      (hsel),
    .htrans    (htrans),
    .hready    (hready),
    .addr_lo   (haddr[1:0]),
    .hsize     (hsize),
    .hreadyout (hreadyout),
    .hresp     (hresp),
    .mem_we    (mem_we)
);

// File: tb/sim_ahbl_sram_sub.sv
`timescale 1ns/1ps
module sim_ahbl_sram_sub;
    localparam int BW = 2;

    logic        hclk;
    logic        hresetn;
    logic        hsel;
    logic [31:0] haddr;
    logic [1:0]  htrans;
    logic        hwrite;
    logic [2:0]  hsize;
    logic [31:0] hwdata;
    logic        hready;
    logic [31:0] hrdata;
    logic        hreadyout;
    logic        hresp;

    int    checks = 0;
    int    fails  = 0;
    int    cyc    = 0;
    bit    finished = 0;
    string cur_tag = "R2";
    logic [31:0] pend_wd = 32'h0;

    typedef enum {P_OPEN, P_WAIT, P_DONE, P_E1, P_E2} mph_t;
    mph_t        mph = P_OPEN;
    logic [31:0] m_addr = 32'h0;
    logic        m_wr = 1'b0;
    logic [2:0]  m_size = 3'd0;
    int          m_left = 0;
    logic [7:0]  ref_mem [int unsigned];

    ahbl_sram_sub #(.WAIT_STATES(BW)) u0 (
        .hclk(hclk), .hresetn(hresetn), .hsel(hsel), .haddr(haddr),
        .htrans(htrans), .hwrite(hwrite), .hsize(hsize), .hwdata(hwdata),
        .hready(hready), .hrdata(hrdata), .hreadyout(hreadyout), .hresp(hresp)
    );

    assign hready = hreadyout;

    initial hclk = 1'b0;
    always #2.5 hclk = ~hclk;

    function automatic bit refused(input logic [31:0] a, input logic [2:0] s);
        return (a >= 32'h400) || (s > 3'd2) || ((a & ((32'd1 << s) - 32'd1)) != 0);
    endfunction

    function automatic logic [31:0] exp_word(input logic [31:0] a);
        logic [31:0] b;
        logic [31:0] w;
        b = a & ~32'h3;
        for (int k = 0; k < 4; k++)
            w[8*k +: 8] = ref_mem.exists(b + k) ? ref_mem[b + k] : 8'h00;
        return w;
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // behavioural reference, steps at every rising edge
    always @(posedge hclk) begin
        int unsigned nb;
        int unsigned base;
        if (!hresetn) begin
            mph = P_OPEN;
        end else begin
            if (mph == P_DONE && m_wr) begin
                nb   = 1 << m_size;
                base = m_addr & ~(nb - 1);
                for (int unsigned k = 0; k < nb; k++)
                    ref_mem[base + k] = hwdata[8*((base + k) % 4) +: 8];
            end
            if (mph == P_OPEN || mph == P_DONE || mph == P_E2) begin
                if (hsel && htrans[1]) begin
                    m_addr = haddr; m_wr = hwrite; m_size = hsize;
                    if (refused(haddr, hsize)) mph = P_E1;
                    else if (BW == 0)          mph = P_DONE;
                    else begin mph = P_WAIT; m_left = BW; end
                end else begin
                    mph = P_OPEN;
                end
            end else if (mph == P_E1) begin
                mph = P_E2;
            end else if (mph == P_WAIT) begin
                m_left--;
                if (m_left == 0) mph = P_DONE;
            end
        end
    end

    // compare every clock, after outputs settle
    always @(posedge hclk) begin
        logic  er;
        logic  ee;
        string tg;
        #1;
        if (hresetn && !finished) begin
            er = !(mph == P_WAIT || mph == P_E1);
            ee = (mph == P_E1 || mph == P_E2);
            tg = (mph == P_WAIT) ? "R4" : cur_tag;
            check(hreadyout == er, tg, "hreadyout", 32'(hreadyout), 32'(er));
            check(hresp == ee, tg, "hresp", 32'(hresp), 32'(ee));
            if (mph == P_DONE && !m_wr)
                check(hrdata == exp_word(m_addr), cur_tag, "hrdata", hrdata, exp_word(m_addr));
        end
    end

    always @(posedge hclk) begin
        cyc++;
        if (cyc > 20000 && !finished) begin
            finished = 1;
            checks++; fails++;
            $display("FAIL R4 watchdog cycles=%0d expected below 20000", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    // one address phase; holds previous write data until its completion
    task automatic issue(input logic [31:0] a, input logic w, input logic [2:0] s,
                         input logic [31:0] wd, input logic [1:0] tr, input logic sel);
        hwdata = pend_wd;
        hsel = sel; haddr = a; hwrite = w; hsize = s; htrans = tr;
        while (!hready) @(negedge hclk);
        @(negedge hclk);
        if (sel && tr[1]) pend_wd = wd;
    endtask

    task automatic wr(input logic [31:0] a, input logic [2:0] s, input logic [31:0] d);
        issue(a, 1'b1, s, d, 2'b10, 1'b1);
    endtask

    task automatic rd(input logic [31:0] a);
        issue(a, 1'b0, 3'd2, 32'h0, 2'b10, 1'b1);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) issue(32'h0, 1'b0, 3'd2, 32'h0, 2'b00, 1'b0);
    endtask

    initial begin
        hresetn = 1'b0; hsel = 1'b0; haddr = '0; htrans = 2'b00;
        hwrite = 1'b0; hsize = 3'd2; hwdata = '0;
        repeat (3) @(negedge hclk);
        check(hreadyout == 1'b1 && hresp == 1'b0, "R1", "ready/resp in reset",
              {30'h0, hreadyout, hresp}, 32'h2);
        hresetn = 1'b1;
        @(negedge hclk);
        check(hreadyout == 1'b1 && hresp == 1'b0, "R1", "ready/resp after reset",
              {30'h0, hreadyout, hresp}, 32'h2);

        cur_tag = "R3";
        for (int i = 0; i < 8; i++) wr(32'(4 * i), 3'd2, 32'hA5C3_0F00 + 32'(i) * 32'h0102_0304);
        idle(2);
        cur_tag = "R5";
        for (int i = 0; i < 8; i++) rd(32'(4 * i));
        idle(2);

        cur_tag = "R8";
        wr(32'h005, 3'd0, 32'h1111_EE11);
        wr(32'h007, 3'd0, 32'h7722_3344);
        wr(32'h00A, 3'd1, 32'hBEEF_5566);
        wr(32'h00C, 3'd1, 32'h7788_1234);
        idle(1);
        rd(32'h004); rd(32'h008); rd(32'h00C);
        idle(2);

        cur_tag = "R2";
        issue(32'h000, 1'b1, 3'd2, 32'hDEAD_0001, 2'b00, 1'b1);
        issue(32'h004, 1'b1, 3'd2, 32'hDEAD_0002, 2'b01, 1'b1);
        issue(32'h008, 1'b1, 3'd2, 32'hDEAD_0003, 2'b10, 1'b0);
        rd(32'h000); rd(32'h004); rd(32'h008);
        idle(2);

        cur_tag = "R6";
        wr(32'h400, 3'd2, 32'h5555_5555);
        idle(2);
        rd(32'hFFFF_FFFC);
        wr(32'h404, 3'd2, 32'h6666_6666);
        idle(2);

        cur_tag = "R7";
        wr(32'h002, 3'd2, 32'h7777_7777);
        idle(1);
        wr(32'h011, 3'd1, 32'h8888_8888);
        wr(32'h018, 3'd3, 32'h9999_9999);
        rd(32'h003);
        idle(2);

        cur_tag = "R9";
        rd(32'h000); rd(32'h004); rd(32'h010); rd(32'h018);
        idle(2);

        cur_tag = "R10";
        wr(32'h010, 3'd2, 32'h0BAD_CAFE);
        rd(32'h010);
        wr(32'h014, 3'd0, 32'h0000_00AB);
        rd(32'h014);
        idle(2);

        cur_tag = "R4";
        rd(32'h01C);
        idle(1);
        wr(32'h01C, 3'd2, 32'hFACE_0000);
        rd(32'h01C);
        idle(3);

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule